// File: doc/BRIEF.md
# Video processor control port decoder

This block sits behind the 16-bit control port of a tile-based video display processor. Every write on that port is classified as a register write, the first word of a memory access command, or the second word that completes one. From these words the block builds a 17-bit memory address and a 6-bit access code. It tracks whether a command is half written. It also gates the topmost code bit with the DMA-enable mode bit and asks the DMA engine to start when that bit ends up set.

The block does not contain the register file, the video memory, the write FIFO, the DMA engine or the video timing. It reaches them only through strobes and flags. Register writes leave as a one-cycle write pulse carrying an index and a value. The block keeps private copies of the few mode bits its own decoding depends on: the H/V capture bit, the DMA-enable bit and the extended-mode bit.

Accesses through the data port, and reads of the control port, abandon a half-written command. A control-port read returns a status word assembled from the FIFO-empty flag, an open-bus value and the remaining status flags. An 8-bit compatibility data read forces the access code to the byte-wide memory-read code.

Top module: `vcp_decoder`

## Requirements
- R1: After reset, `addr`, `code` and `cmd_pending` are all zero, and no output pulse (`reg_we`, `hv_capture`, `dma_req`, `rdstate_clr`) is high.
- R2: A `ctrl_wr` while `dma_busy` is high changes neither `addr`, `code` nor `cmd_pending`, and it produces no pulse.
- R3: A control write with no command pending sets `addr[13:0]` to data bits 13:0 and `code[1:0]` to data bits 15:14. It sets `addr[16:14]` to the upper-address latch, which holds whatever value the last second word left in it (zero after reset).
- R4: A control write with no command pending whose bits 15:14 are 2'b10 is a register write. In the next cycle `reg_we` pulses, with `reg_idx` equal to data bits 12:8 and `reg_val` equal to data bits 7:0. `cmd_pending` stays 0.
- R5: A register write is accepted only if its index is below 24 in extended mode, and below 11 otherwise. Extended mode is bit 2 of an accepted write to register 1. A rejected register write gives no `reg_we` pulse and changes no mode bit.
- R6: Any other control write with no command pending sets `cmd_pending`.
- R7: A control write while `cmd_pending` is set is the second word. Data bits 2:0 go into the upper-address latch and into `addr[16:14]`. Data bits 6:4 go into `code[4:2]`. `cmd_pending` clears, and `rdstate_clr` pulses in the next cycle.
- R8: On the second word, `code[5]` takes data bit 7 only when DMA-enable (bit 4 of the last accepted write to register 1) is set. Otherwise `code[5]` keeps its value.
- R9: When `code[5]` is 1 after a second word, `dma_req` pulses in the cycle after that word.
- R10: `data_wr`, `data_rd` and `ctrl_rd` each clear `cmd_pending`. `data_wr` and `data_rd` also pulse `rdstate_clr` in the next cycle; `ctrl_rd` does not.
- R11: An accepted write to register 0 with bit 1 set, when the held copy of that bit is 0, pulses `hv_capture` for one cycle in the next cycle. The held copy then takes the written bit.
- R12: `status_word` is `{open_bus, fifo_empty, flag_bits}`. Bits 15:10 come from `open_bus`, bit 9 is the FIFO-empty flag and bits 8:0 come from `flag_bits`. It is combinational in the default build.
- R13: `data_rd8` sets `code` to 6'b001100, clears `cmd_pending` and pulses `rdstate_clr` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control-port write strobe |
| ctrl_wdata | input | 16 | Control-port write word |
| ctrl_rd | input | 1 | Control-port (status) read strobe |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| data_rd8 | input | 1 | 8-bit compatibility data read strobe |
| dma_busy | input | 1 | A DMA transfer is running |
| fifo_empty | input | 1 | Write FIFO is empty |
| open_bus | input | 6 | Open-bus value for status bits 15:10 |
| flag_bits | input | 9 | Other status flags for bits 8:0 |
| addr | output | 17 | Current access address |
| code | output | 6 | Current access code |
| cmd_pending | output | 1 | First command word seen, second awaited |
| reg_we | output | 1 | Register write pulse |
| reg_idx | output | 5 | Register index, valid with reg_we |
| reg_val | output | 8 | Register value, valid with reg_we |
| hv_capture | output | 1 | Pulse to capture the H/V counter |
| dma_req | output | 1 | Pulse requesting a DMA start |
| rdstate_clr | output | 1 | Pulse clearing the read-prefetched and read-pending flags |
| status_word | output | 16 | Status word for control-port reads |

## Verification
The properties assume that at most one of the five port strobes is high in any cycle. Where several would collide, the decoder's priority among them is not a specified behaviour. The bench therefore issues exactly one strobe per operation, followed by an idle cycle, and its random mix draws a single operation kind each time. The random control words are biased toward the 2'b10 prefix and toward indices around the two acceptance limits. The busy input is raised only alongside control writes, so that the rejected-write property and the second-word properties are both reached often.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

   // classification of one control-port cycle
   typedef enum logic [1:0] {
      WK_NONE   = 2'd0,
      WK_FIRST  = 2'd1,
      WK_REG    = 2'd2,
      WK_SECOND = 2'd3
   } word_kind_e;

   // fixed bit positions inside a control word
   localparam int TAG_HI      = 15;
   localparam int TAG_LO      = 14;
   localparam int IDX_HI      = 12;
   localparam int IDX_LO      = 8;
   localparam int CODE_MID_HI = 6;
   localparam int CODE_MID_LO = 4;
   localparam int CODE_TOP_SRC = 7;

   // mode bits that the decoder itself depends on
   localparam int MODE_A_IDX  = 0;
   localparam int HV_BIT      = 1;
   localparam int MODE_B_IDX  = 1;
   localparam int DMAEN_BIT   = 4;
   localparam int EXT_BIT     = 2;

   localparam logic [1:0] TAG_REGWR = 2'b10;

   function automatic word_kind_e classify(input logic wr, input logic busy,
                                           input logic pend, input logic [1:0] tag);
      if (!wr || busy)          return WK_NONE;
      else if (pend)            return WK_SECOND;
      else if (tag == TAG_REGWR) return WK_REG;
      else                      return WK_FIRST;
   endfunction

endpackage

// File: rtl/vcp_cmd_assembler.sv
module vcp_cmd_assembler
   import vcp_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int LO_W   = 14,
   parameter int CODE_W = 6,
   parameter logic [5:0] CODE_RD8 = 6'b001100
) (
   input  logic              clk,
   input  logic              rst,
   input  word_kind_e        kind,
   input  logic [15:0]       wdata,
   input  logic              dma_en,
   input  logic              ctrl_rd,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic              data_rd8,
   output logic [ADDR_W-1:0] addr,
   output logic [CODE_W-1:0] code,
   output logic              pending,
   output logic [ADDR_W-LO_W-1:0] upper,
   output logic              dma_req,
   output logic              rd_clr
);
   localparam int HI_W = ADDR_W - LO_W;

   if (HI_W < 1 || HI_W > CODE_MID_LO) begin : g_bad_split
      $error("vcp_cmd_assembler: upper address field must be 1..4 bits");
   end
   if (CODE_W != 6) begin : g_bad_code
      $error("vcp_cmd_assembler: access code must be 6 bits");
   end

   logic top_next;
   assign top_next = dma_en ? wdata[CODE_TOP_SRC] : code[CODE_W-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         addr    <= '0;
         code    <= '0;
         pending <= 1'b0;
         upper   <= '0;
         dma_req <= 1'b0;
         rd_clr  <= 1'b0;
      end else begin
         dma_req <= 1'b0;
         rd_clr  <= 1'b0;
         case (kind)
            WK_FIRST, WK_REG: begin
               addr      <= {upper, wdata[LO_W-1:0]};
               code[1:0] <= wdata[TAG_HI:TAG_LO];
               if (kind == WK_FIRST) pending <= 1'b1;
            end
            WK_SECOND: begin
               upper                   <= wdata[HI_W-1:0];
               addr[ADDR_W-1:LO_W]     <= wdata[HI_W-1:0];
               code[CODE_W-2:2]        <= wdata[CODE_MID_HI:CODE_MID_LO];
               code[CODE_W-1]          <= top_next;
               pending                 <= 1'b0;
               rd_clr                  <= 1'b1;
               dma_req                 <= top_next;
            end
            default: ;
         endcase
         if (ctrl_rd) pending <= 1'b0;
         if (data_wr || data_rd) begin
            pending <= 1'b0;
            rd_clr  <= 1'b1;
         end
         if (data_rd8) begin
            pending <= 1'b0;
            rd_clr  <= 1'b1;
            code    <= CODE_RD8;
         end
      end
   end
endmodule

// File: rtl/vcp_reg_decoder.sv
module vcp_reg_decoder
   import vcp_pkg::*;
#(
   parameter int IDX_W          = 5,
   parameter int VAL_W          = 8,
   parameter int REG_CNT        = 24,
   parameter int REG_CNT_LEGACY = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             is_reg,
   input  logic [IDX_HI:0]  wdata,
   output logic             reg_we,
   output logic [IDX_W-1:0] reg_idx,
   output logic [VAL_W-1:0] reg_val,
   output logic             hv_capture,
   output logic             dma_en,
   output logic             ext_mode
);
   localparam int IDX_SPAN = 1 << IDX_W;

   if (REG_CNT > IDX_SPAN || REG_CNT_LEGACY > REG_CNT) begin : g_bad_count
      $error("vcp_reg_decoder: register counts out of range");
   end
   if (IDX_W != IDX_HI - IDX_LO + 1 || VAL_W != IDX_LO) begin : g_bad_field
      $error("vcp_reg_decoder: index/value widths do not fit the word");
   end

   logic [IDX_W-1:0] idx;
   logic [VAL_W-1:0] val;
   logic             accept;
   logic             hv_held;

   assign idx    = wdata[IDX_HI:IDX_LO];
   assign val    = wdata[VAL_W-1:0];
   assign accept = is_reg && (int'(idx) < (ext_mode ? REG_CNT : REG_CNT_LEGACY));

   always_ff @(posedge clk) begin
      if (rst) begin
         reg_we     <= 1'b0;
         reg_idx    <= '0;
         reg_val    <= '0;
         hv_capture <= 1'b0;
         hv_held    <= 1'b0;
         dma_en     <= 1'b0;
         ext_mode   <= 1'b0;
      end else begin
         reg_we     <= accept;
         hv_capture <= 1'b0;
         if (accept) begin
            reg_idx <= idx;
            reg_val <= val;
            if (int'(idx) == MODE_A_IDX) begin
               hv_capture <= val[HV_BIT] && !hv_held;
               hv_held    <= val[HV_BIT];
            end
            if (int'(idx) == MODE_B_IDX) begin
               dma_en   <= val[DMAEN_BIT];
               ext_mode <= val[EXT_BIT];
            end
         end
      end
   end
endmodule

// File: rtl/vcp_status_mux.sv
module vcp_status_mux #(
   parameter int  OB_W      = 6,
   parameter int  FLAG_W    = 9,
   parameter bit  STATUS_REG = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [OB_W-1:0]        open_bus,
   input  logic                   fifo_empty,
   input  logic [FLAG_W-1:0]      flag_bits,
   output logic [OB_W+FLAG_W:0]   status_word
);
   logic [OB_W+FLAG_W:0] word_c;
   assign word_c = {open_bus, fifo_empty, flag_bits};

   if (STATUS_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) status_word <= '0;
         else     status_word <= word_c;
      end
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok   = clk ^ rst;
      assign status_word = word_c;
   end
endmodule

// File: rtl/vcp_decoder.sv
module vcp_decoder
   import vcp_pkg::*;
#(
   parameter int  ADDR_W         = 17,
   parameter int  LO_W           = 14,
   parameter int  CODE_W         = 6,
   parameter int  IDX_W          = 5,
   parameter int  VAL_W          = 8,
   parameter int  REG_CNT        = 24,
   parameter int  REG_CNT_LEGACY = 11,
   parameter int  OB_W           = 6,
   parameter int  FLAG_W         = 9,
   parameter bit  STATUS_REG     = 1'b0,
   parameter logic [5:0] CODE_RD8 = 6'b001100
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ctrl_wr,
   input  logic [15:0]          ctrl_wdata,
   input  logic                 ctrl_rd,
   input  logic                 data_wr,
   input  logic                 data_rd,
   input  logic                 data_rd8,
   input  logic                 dma_busy,
   input  logic                 fifo_empty,
   input  logic [OB_W-1:0]      open_bus,
   input  logic [FLAG_W-1:0]    flag_bits,
   output logic [ADDR_W-1:0]    addr,
   output logic [CODE_W-1:0]    code,
   output logic                 cmd_pending,
   output logic                 reg_we,
   output logic [IDX_W-1:0]     reg_idx,
   output logic [VAL_W-1:0]     reg_val,
   output logic                 hv_capture,
   output logic                 dma_req,
   output logic                 rdstate_clr,
   output logic [OB_W+FLAG_W:0] status_word
);
   localparam int HI_W = ADDR_W - LO_W;

   if (OB_W + FLAG_W + 1 != 16) begin : g_bad_status
      $error("vcp_decoder: status word must be 16 bits");
   end

   word_kind_e      kind;
   logic            dma_en_q;
   logic            ext_mode_q;
   logic [HI_W-1:0] upper_q;

   assign kind = classify(ctrl_wr, dma_busy, cmd_pending, ctrl_wdata[TAG_HI:TAG_LO]);

   vcp_cmd_assembler #(
      .ADDR_W(ADDR_W), .LO_W(LO_W), .CODE_W(CODE_W), .CODE_RD8(CODE_RD8)
   ) u_cmd (
      .clk(clk), .rst(rst), .kind(kind), .wdata(ctrl_wdata), .dma_en(dma_en_q),
      .ctrl_rd(ctrl_rd), .data_wr(data_wr), .data_rd(data_rd), .data_rd8(data_rd8),
      .addr(addr), .code(code), .pending(cmd_pending), .upper(upper_q),
      .dma_req(dma_req), .rd_clr(rdstate_clr)
   );

   vcp_reg_decoder #(
      .IDX_W(IDX_W), .VAL_W(VAL_W), .REG_CNT(REG_CNT), .REG_CNT_LEGACY(REG_CNT_LEGACY)
   ) u_reg (
      .clk(clk), .rst(rst), .is_reg(kind == WK_REG), .wdata(ctrl_wdata[IDX_HI:0]),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val), .hv_capture(hv_capture),
      .dma_en(dma_en_q), .ext_mode(ext_mode_q)
   );

   vcp_status_mux #(
      .OB_W(OB_W), .FLAG_W(FLAG_W), .STATUS_REG(STATUS_REG)
   ) u_stat (
      .clk(clk), .rst(rst), .open_bus(open_bus), .fifo_empty(fifo_empty),
      .flag_bits(flag_bits), .status_word(status_word)
   );
endmodule

// File: rtl/vcp_decoder_chk.sv
module vcp_decoder_chk #(
   parameter int REG_CNT_LEGACY = 11,
   parameter bit STATUS_REG     = 1'b0
) (
   input logic        clk,
   input logic        rst,
   input logic        ctrl_wr,
   input logic [15:0] ctrl_wdata,
   input logic        ctrl_rd,
   input logic        data_wr,
   input logic        data_rd,
   input logic        data_rd8,
   input logic        dma_busy,
   input logic        fifo_empty,
   input logic [5:0]  open_bus,
   input logic [8:0]  flag_bits,
   input logic [16:0] addr,
   input logic [5:0]  code,
   input logic        cmd_pending,
   input logic        reg_we,
   input logic [4:0]  reg_idx,
   input logic        dma_req,
   input logic        rdstate_clr,
   input logic [15:0] status_word,
   input logic        dma_en_q,
   input logic        ext_mode_q,
   input logic [2:0]  upper_q
);
   logic solo;
   assign solo = $countones({ctrl_wr, ctrl_rd, data_wr, data_rd, data_rd8}) <= 1;

   // input assumption: one strobe per cycle
   strobe_solo_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctrl_wr, ctrl_rd, data_wr, data_rd, data_rd8}));

   // R2
   busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
      (solo && ctrl_wr && dma_busy) |=>
         ($stable(addr) && $stable(code) && $stable(cmd_pending) && !reg_we && !rdstate_clr));

   // R3
   first_word_chk: assert property (@(posedge clk) disable iff (rst)
      (solo && ctrl_wr && !dma_busy && !cmd_pending) |=>
         (addr[13:0] == $past(ctrl_wdata[13:0]) && code[1:0] == $past(ctrl_wdata[15:14])
          && addr[16:14] == $past(upper_q)));

   // R4
   regwr_keeps_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (solo && ctrl_wr && !dma_busy && !cmd_pending && ctrl_wdata[15:14] == 2'b10) |=>
         !cmd_pending);

   // R5
   reg_limit_chk: assert property (@(posedge clk) disable iff (rst)
      reg_we |-> (int'(reg_idx) < REG_CNT_LEGACY || $past(ext_mode_q)));

   // R6
   cmd_opens_chk: assert property (@(posedge clk) disable iff (rst)
      (solo && ctrl_wr && !dma_busy && !cmd_pending && ctrl_wdata[15:14] != 2'b10) |=>
         cmd_pending);

   // R7
   second_word_chk: assert property (@(posedge clk) disable iff (rst)
      (solo && ctrl_wr && !dma_busy && cmd_pending) |=>
         (addr[16:14] == $past(ctrl_wdata[2:0]) && code[4:2] == $past(ctrl_wdata[6:4])
          && !cmd_pending && rdstate_clr));

   // R8
   top_code_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (solo && ctrl_wr && !dma_busy && cmd_pending && !dma_en_q) |=>
         (code[5] == $past(code[5])));

   // R9
   dma_req_code_chk: assert property (@(posedge clk) disable iff (rst)
      dma_req |-> (code[5] && !cmd_pending));

   // R10
   data_cancel_chk: assert property (@(posedge clk) disable iff (rst)
      (solo && (data_wr || data_rd)) |=> (!cmd_pending && rdstate_clr));

   // R10
   status_cancel_chk: assert property (@(posedge clk) disable iff (rst)
      (solo && ctrl_rd) |=> (!cmd_pending && !rdstate_clr));

   // R13
   byte_read_code_chk: assert property (@(posedge clk) disable iff (rst)
      (solo && data_rd8) |=> (code == 6'b001100 && !cmd_pending));

   if (!STATUS_REG) begin : g_stat
      // R12
      status_pack_chk: assert property (@(posedge clk) disable iff (rst)
         status_word == {open_bus, fifo_empty, flag_bits});
   end
endmodule

bind vcp_decoder vcp_decoder_chk #(
   .REG_CNT_LEGACY(REG_CNT_LEGACY), .STATUS_REG(STATUS_REG)
) u_chk (
   .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd),
   .data_wr(data_wr), .data_rd(data_rd), .data_rd8(data_rd8), .dma_busy(dma_busy),
   .fifo_empty(fifo_empty), .open_bus(open_bus), .flag_bits(flag_bits),
   .addr(addr), .code(code), .cmd_pending(cmd_pending), .reg_we(reg_we),
   .reg_idx(reg_idx), .dma_req(dma_req), .rdstate_clr(rdstate_clr),
   .status_word(status_word), .dma_en_q(dma_en_q), .ext_mode_q(ext_mode_q),
   .upper_q(upper_q)
);

// File: tb/vcp_decoder_test.sv
`timescale 1ns/1ps
module vcp_decoder_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        ctrl_wr, ctrl_rd, data_wr, data_rd, data_rd8, dma_busy, fifo_empty;
   logic [15:0] ctrl_wdata;
   logic [5:0]  open_bus;
   logic [8:0]  flag_bits;
   logic [16:0] addr;
   logic [5:0]  code;
   logic        cmd_pending, reg_we, hv_capture, dma_req, rdstate_clr;
   logic [4:0]  reg_idx;
   logic [7:0]  reg_val;
   logic [15:0] status_word;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   // expected-state model
   logic [16:0] m_addr;
   logic [5:0]  m_code;
   logic        m_pend, m_hv, m_dmaen, m_ext;
   logic [2:0]  m_up;

   always #2.5 clk = ~clk;

   vcp_decoder uut (
      .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd),
      .data_wr(data_wr), .data_rd(data_rd), .data_rd8(data_rd8), .dma_busy(dma_busy),
      .fifo_empty(fifo_empty), .open_bus(open_bus), .flag_bits(flag_bits),
      .addr(addr), .code(code), .cmd_pending(cmd_pending), .reg_we(reg_we),
      .reg_idx(reg_idx), .reg_val(reg_val), .hv_capture(hv_capture), .dma_req(dma_req),
      .rdstate_clr(rdstate_clr), .status_word(status_word)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_status(logic [5:0] ob, logic fe, logic [8:0] fl);
      return {ob, fe, fl};
   endfunction

   // op kinds: 0 control write, 1 control read, 2 data write, 3 data read, 4 byte read
   task automatic run_op(int kind, logic [15:0] d, bit busy);
      logic e_we, e_hv, e_dma, e_clr;
      logic [4:0] e_idx;
      logic [7:0] e_val;
      string tag;
      e_we = 0; e_hv = 0; e_dma = 0; e_clr = 0; e_idx = '0; e_val = '0;
      tag = "R10";
      @(negedge clk);
      ctrl_wr  = (kind == 0);
      ctrl_rd  = (kind == 1);
      data_wr  = (kind == 2);
      data_rd  = (kind == 3);
      data_rd8 = (kind == 4);
      dma_busy = busy;
      ctrl_wdata = d;
      open_bus = 6'($urandom); fifo_empty = 1'($urandom); flag_bits = 9'($urandom);
      #1;
      // R12: status packing
      check("R12", "status_word", 32'(status_word), 32'(exp_status(open_bus, fifo_empty, flag_bits)));
      if (kind == 0) begin
         if (busy) tag = "R2";
         else if (!m_pend) begin
            m_addr = {m_up, d[13:0]};
            m_code[1:0] = d[15:14];
            if (d[15:14] == 2'b10) begin
               tag = "R4";
               if (int'(d[12:8]) < (m_ext ? 24 : 11)) begin
                  e_we = 1; e_idx = d[12:8]; e_val = d[7:0];
                  if (d[12:8] == 5'd0) begin
                     tag = "R11";
                     e_hv = d[1] && !m_hv;
                     m_hv = d[1];
                  end
                  if (d[12:8] == 5'd1) begin m_dmaen = d[4]; m_ext = d[2]; end
               end else tag = "R5";
            end else begin
               tag = "R6";
               m_pend = 1;
            end
         end else begin
            tag = "R7";
            m_up = d[2:0];
            m_addr[16:14] = d[2:0];
            m_code[4:2] = d[6:4];
            if (m_dmaen) m_code[5] = d[7];
            else tag = "R8";
            m_pend = 0;
            e_clr = 1;
            e_dma = m_code[5];
            if (e_dma) tag = "R9";
         end
      end else if (kind == 1) begin
         m_pend = 0;
      end else if (kind == 2 || kind == 3) begin
         m_pend = 0; e_clr = 1;
      end else if (kind == 4) begin
         tag = "R13";
         m_pend = 0; e_clr = 1; m_code = 6'b001100;
      end
      @(negedge clk);
      ctrl_wr = 0; ctrl_rd = 0; data_wr = 0; data_rd = 0; data_rd8 = 0; dma_busy = 0;
      // R3: address and code tracking
      check(tag, "addr", 32'(addr), 32'(m_addr));
      check(tag, "code", 32'(code), 32'(m_code));
      check(tag, "cmd_pending", 32'(cmd_pending), 32'(m_pend));
      check(tag, "reg_we", 32'(reg_we), 32'(e_we));
      if (e_we) begin
         check(tag, "reg_idx", 32'(reg_idx), 32'(e_idx));
         check(tag, "reg_val", 32'(reg_val), 32'(e_val));
      end
      check(tag, "hv_capture", 32'(hv_capture), 32'(e_hv));
      check(tag, "dma_req", 32'(dma_req), 32'(e_dma));
      check(tag, "rdstate_clr", 32'(rdstate_clr), 32'(e_clr));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int sd;
      sd = $urandom(32'd4711);
      rst = 1; ctrl_wr = 0; ctrl_rd = 0; data_wr = 0; data_rd = 0; data_rd8 = 0;
      dma_busy = 0; fifo_empty = 0; open_bus = '0; flag_bits = '0; ctrl_wdata = '0;
      m_addr = '0; m_code = '0; m_pend = 0; m_hv = 0; m_dmaen = 0; m_ext = 0; m_up = '0;
      repeat (4) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1: reset state
      check("R1", "addr", 32'(addr), 0);
      check("R1", "code", 32'(code), 0);
      check("R1", "cmd_pending", 32'(cmd_pending), 0);
      check("R1", "pulses", 32'({reg_we, hv_capture, dma_req, rdstate_clr}), 0);

      // directed corners
      run_op(0, 16'h8A55, 0);   // R5: index 10 accepted in legacy mode
      run_op(0, 16'h8B55, 0);   // R5: index 11 rejected in legacy mode
      run_op(0, 16'h4123, 0);   // R6: first word
      run_op(0, 16'h00F5, 1);   // R2: rejected while busy
      run_op(0, 16'h00F5, 0);   // R7/R8: second word, DMA disabled
      run_op(0, 16'h4000, 0);   // R3: upper latch reused
      run_op(2, 16'h0000, 0);   // R10: data write cancels
      run_op(0, 16'h8114, 0);   // enable DMA and extended mode
      run_op(0, 16'h9777, 0);   // R5: index 23 accepted
      run_op(0, 16'h9877, 0);   // R5: index 24 rejected
      run_op(0, 16'h8002, 0);   // R11: capture pulse
      run_op(0, 16'h8002, 0);   // R11: no second pulse
      run_op(0, 16'h7FFF, 0);
      run_op(0, 16'h0086, 0);   // R9: code[5] set, request
      run_op(0, 16'h8100, 0);   // disable DMA
      run_op(0, 16'h4001, 0);
      run_op(0, 16'h0000, 0);   // R8: code[5] kept, R9 request again
      run_op(0, 16'h4001, 0);
      run_op(1, 16'h0000, 0);   // R10: status read cancels
      run_op(0, 16'h4001, 0);
      run_op(4, 16'h0000, 0);   // R13
      run_op(0, 16'h4001, 0);
      run_op(3, 16'h0000, 0);   // R10: data read cancels

      for (int i = 0; i < 1500; i++) begin
         int k;
         logic [15:0] d;
         bit b;
         k = ($urandom % 10 < 6) ? 0 : int'(1 + $urandom % 4);
         d = 16'($urandom);
         if ($urandom % 3 == 0) begin
            d[15:14] = 2'b10;
            d[12:8] = 5'($urandom % 26);
            if ($urandom % 4 == 0) d[12:8] = 5'($urandom % 2);
         end
         b = (k == 0) && ($urandom % 6 == 0);
         run_op(k, d, b);
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule